// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the status-register path of a SPI serial flash slave. It watches chip select, serial clock and serial data in from the host, all oversampled by the chip's system clock. It decodes three instructions: set write-enable, read status, and write status. It holds the write-enable latch, the protection bits and a protect-lock bit. After an accepted status write it runs a busy cycle of fixed length. The status byte can be polled on serial data out during that cycle.

Two things gate a status write. The frame must end exactly on its sixteenth bit, and the write-enable latch must already be set. A status-protect bit together with a low write-protect pin locks writes out. In one-time-programmable mode a status write sets a sticky lock flag and leaves the register alone. The controller also keeps a volatile fail flag and two suspend flags. The erase and program engines drive these flags through single-cycle strobes.

Top module: `sfsr_status_ctrl`

## Requirements
- R1: After reset, the status byte reads 00h, `miso` is 0, and `fail_o`, `wse_o`, `wsp_o`, `otp_lock_o` and `wip_o` are 0.
- R2: Opcode 05h (read status) drives the status byte on `miso`, MSB first, changing on falling `sclk` (SPI mode 0). The first bit appears on the falling edge after the eighth opcode bit. The byte is re-read and sent again every further 8 bits while `cs_n` stays low. Byte layout: bit7 status-protect, bit6 always 0, bits5:2 protection field, bit1 write-enable latch, bit0 busy.
- R3: Opcode 06h sets the write-enable latch only when `cs_n` rises after exactly 8 bits. Any other length leaves the latch unchanged.
- R4: Opcode 01h (write status) has no effect unless the write-enable latch is 1.
- R5: A write-status frame is executed only if `cs_n` rises after exactly 16 bits (opcode plus one data byte). Shorter or longer frames are cancelled.
- R6: An accepted write-status holds `wip_o` and status bit0 at 1 for exactly `WR_CYCLES` clock cycles. Status stays readable throughout.
- R7: The write-enable latch clears in the same cycle the busy cycle ends.
- R8: An accepted write takes data bit7 into status-protect and data bits5:2 into the protection field. Data bits 6, 1 and 0 are ignored. Those fields change at no other time.
- R9: While status-protect is 1 and `wp_n` is 0, write-status is not executed and the write-enable latch keeps its value.
- R10: With `otp_mode` high, an accepted write-status leaves status bits 7 and 5:2 unchanged, sets `otp_lock_o` (sticky until reset) and still runs the busy cycle.
- R11: `op_fail` sets `fail_o`. `op_start` or `soft_rst` clears it. `op_fail` wins when both arrive in the same cycle.
- R12: `susp_req` sets `wse_o` when `op_erase` is 1, otherwise `wsp_o`. `resume_req` clears both and wins over a same-cycle `susp_req`.
- R13: While busy, every instruction except read status is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | One-time-programmable mode select |
| susp_req | input | 1 | Suspend strobe from the active engine |
| resume_req | input | 1 | Resume strobe |
| op_erase | input | 1 | 1 when the running operation is an erase, 0 for program |
| op_start | input | 1 | Strobe: a new program or erase starts |
| op_fail | input | 1 | Strobe: a write-status, erase or program failed |
| soft_rst | input | 1 | Software reset strobe |
| wip_o | output | 1 | Busy flag |
| fail_o | output | 1 | Volatile fail flag |
| wse_o | output | 1 | Erase suspended flag |
| wsp_o | output | 1 | Program suspended flag |
| otp_lock_o | output | 1 | Sticky lock set by a write in OTP mode |

## Verification
Write-status frames are sent with exact, short and long bit counts, with and without the write-enable latch set, and with the write-protect pin both high and low. This separates the frame-length rule from the latch rule and from hardware protection. A read issued during the busy cycle, and a two-byte read, show that the status byte is live and is resent on every byte. Random mixes of set-enable, write-status with random data, wrong-length frames, unknown opcodes and pin toggles are compared against a bench model. Directed strobe pairs on the flag inputs settle the same-cycle priorities.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef struct packed {
    logic       srp;
    logic [3:0] bp;
    logic       wel;
    logic       wip;
  } stat_t;

  function automatic logic [7:0] pack_status(stat_t s);
    return {s.srp, 1'b0, s.bp, s.wel, s.wip};
  endfunction
endpackage

// File: rtl/sfsr_spi_rx.sv
module sfsr_spi_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             mosi,
  input  logic             wp_n,
  output logic             wp_s,
  output logic             sclk_fall,
  output logic             cs_rise,
  output logic [CNT_W-1:0] frame_bits,
  output logic [2:0]       bit_ph,
  output logic [7:0]       opcode,
  output logic [7:0]       data,
  output logic             op_valid
);
  localparam int NPIN = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [NPIN-1:0] PIN_RST = 4'b1001; // wp_n, mosi, sclk, cs_n

  logic [NPIN-1:0] stg [SYNC_STAGES];
  logic [NPIN-1:0] pins_s;
  logic            sck_q, cs_q;
  logic [7:0]      sh;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= PIN_RST;
        else if (g == 0) stg[g] <= {wp_n, mosi, sclk, cs_n};
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign pins_s = stg[SYNC_STAGES-1];
  assign wp_s   = pins_s[3];

  logic cs_low, sck_rise, bit_in;
  assign cs_low    = ~pins_s[0];
  assign bit_in    = pins_s[2];
  assign sck_rise  = pins_s[1] & ~sck_q & cs_low;
  assign sclk_fall = ~pins_s[1] & sck_q & cs_low;
  assign cs_rise   = pins_s[0] & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      sh         <= '0;
      frame_bits <= '0;
      bit_ph     <= '0;
      opcode     <= '0;
      data       <= '0;
      op_valid   <= 1'b0;
    end else begin
      sck_q <= pins_s[1];
      cs_q  <= pins_s[0];
      if (!cs_low) begin
        frame_bits <= '0;
        bit_ph     <= '0;
        op_valid   <= 1'b0;
      end else if (sck_rise) begin
        sh     <= {sh[6:0], bit_in};
        bit_ph <= bit_ph + 3'd1;
        if (frame_bits != CNT_MAX) frame_bits <= frame_bits + 1'b1;
        if (frame_bits == CNT_W'(7)) begin
          opcode   <= {sh[6:0], bit_in};
          op_valid <= 1'b1;
        end
        if (frame_bits == CNT_W'(15)) data <= {sh[6:0], bit_in};
      end
    end
  end
endmodule

// File: rtl/sfsr_spi_tx.sv
module sfsr_spi_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_active,
  input  logic       sclk_fall,
  input  logic [2:0] bit_ph,
  input  logic [7:0] status,
  output logic       miso
);
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      miso <= 1'b0;
    end else if (!rd_active) begin
      miso <= 1'b0;
    end else if (sclk_fall) begin
      if (bit_ph == 3'd0) begin
        miso <= status[7];
        sh   <= {status[6:0], 1'b0};
      end else begin
        miso <= sh[7];
        sh   <= {sh[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sfsr_core.sv
module sfsr_core
  import sfsr_pkg::*;
#(
  parameter int WR_CYCLES = 64,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_rise,
  input  logic [CNT_W-1:0] frame_bits,
  input  logic             op_valid,
  input  logic [7:0]       opcode,
  input  logic [7:0]       data,
  input  logic             wp_s,
  input  logic             otp_mode,
  output stat_t            st,
  output logic             hpm,
  output logic             otp_lock
);
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  logic [TMR_W-1:0] tmr;
  logic wren_go, wrsr_go, frame_ok;

  assign hpm      = st.srp & ~wp_s;
  assign frame_ok = cs_rise & op_valid & ~st.wip;
  assign wren_go  = frame_ok & (opcode == OP_WREN) & (frame_bits == CNT_W'(8));
  assign wrsr_go  = frame_ok & (opcode == OP_WRSR) & (frame_bits == CNT_W'(16))
                    & st.wel & ~hpm;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= '0;
      tmr      <= '0;
      otp_lock <= 1'b0;
    end else begin
      if (st.wip) begin
        if (tmr == '0) begin
          st.wip <= 1'b0;
          st.wel <= 1'b0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
      if (wren_go) st.wel <= 1'b1;
      if (wrsr_go) begin
        st.wip <= 1'b1;
        tmr    <= TMR_W'(WR_CYCLES - 1);
        if (otp_mode) begin
          otp_lock <= 1'b1;
        end else begin
          st.srp <= data[7];
          st.bp  <= data[5:2];
        end
      end
    end
  end
endmodule

// File: rtl/sfsr_flags.sv
module sfsr_flags (
  input  logic clk,
  input  logic rst,
  input  logic susp_req,
  input  logic resume_req,
  input  logic op_erase,
  input  logic op_start,
  input  logic op_fail,
  input  logic soft_rst,
  output logic fail,
  output logic wse,
  output logic wsp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fail <= 1'b0;
      wse  <= 1'b0;
      wsp  <= 1'b0;
    end else begin
      if (op_fail) fail <= 1'b1;
      else if (op_start || soft_rst) fail <= 1'b0;
      if (resume_req) begin
        wse <= 1'b0;
        wsp <= 1'b0;
      end else if (susp_req) begin
        if (op_erase) wse <= 1'b1;
        else          wsp <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfsr_status_ctrl.sv
module sfsr_status_ctrl
  import sfsr_pkg::*;
#(
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  input  logic wp_n,
  input  logic otp_mode,
  input  logic susp_req,
  input  logic resume_req,
  input  logic op_erase,
  input  logic op_start,
  input  logic op_fail,
  input  logic soft_rst,
  output logic wip_o,
  output logic fail_o,
  output logic wse_o,
  output logic wsp_o,
  output logic otp_lock_o
);
  localparam int CNT_W = 5;

  logic             wp_s, sclk_fall, cs_rise, op_valid, hpm;
  logic [CNT_W-1:0] frame_bits;
  logic [2:0]       bit_ph;
  logic [7:0]       opcode, data;
  stat_t            st;
  logic             wip_q, wel_q, srp_q;
  logic [3:0]       bp_q;

  sfsr_spi_rx #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .wp_n(wp_n),
    .wp_s(wp_s), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
    .frame_bits(frame_bits), .bit_ph(bit_ph), .opcode(opcode), .data(data),
    .op_valid(op_valid)
  );

  sfsr_core #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .frame_bits(frame_bits),
    .op_valid(op_valid), .opcode(opcode), .data(data), .wp_s(wp_s),
    .otp_mode(otp_mode), .st(st), .hpm(hpm), .otp_lock(otp_lock_o)
  );

  sfsr_spi_tx u_tx (
    .clk(clk), .rst(rst), .rd_active(op_valid && (opcode == OP_RDSR)),
    .sclk_fall(sclk_fall), .bit_ph(bit_ph), .status(pack_status(st)),
    .miso(miso)
  );

  sfsr_flags u_flags (
    .clk(clk), .rst(rst), .susp_req(susp_req), .resume_req(resume_req),
    .op_erase(op_erase), .op_start(op_start), .op_fail(op_fail),
    .soft_rst(soft_rst), .fail(fail_o), .wse(wse_o), .wsp(wsp_o)
  );

  assign wip_q = st.wip;
  assign wel_q = st.wel;
  assign srp_q = st.srp;
  assign bp_q  = st.bp;
  assign wip_o = st.wip;
endmodule

// File: rtl/sfsr_checker.sv
module sfsr_checker #(
  parameter int WR_CYCLES = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       wip,
  input logic       wel,
  input logic       srp,
  input logic [3:0] bp,
  input logic       hpm,
  input logic       otp_lock,
  input logic       fail,
  input logic       wse,
  input logic       wsp,
  input logic       op_fail,
  input logic       resume_req
);
  int run;

  always_ff @(posedge clk) begin
    if (rst) run <= 0;
    else     run <= wip ? run + 1 : 0;
  end

  // R6: busy lasts exactly WR_CYCLES cycles
  a_r6_busy_len: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $fell(wip) |-> run == WR_CYCLES);

  // R7: latch is clear once busy ends
  a_r7_wel_clear: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $fell(wip) |-> !wel);

  // R4: a write starts only with the latch set
  a_r4_needs_wel: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $rose(wip) |-> $past(wel));

  // R9: no write starts under hardware protection
  a_r9_hpm_block: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $rose(wip) |-> !$past(hpm));

  // R8: protection fields change only when a write is accepted
  a_r8_fields_change: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$stable({srp, bp}) |-> $rose(wip));

  // R10: lock flag rises only with an accepted write
  a_r10_otp_lock: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $rose(otp_lock) |-> $rose(wip) && $stable({srp, bp}));

  // R11: failure strobe always leaves the flag set
  a_r11_fail_set: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(op_fail) |-> fail);

  // R12: resume clears both suspend flags
  a_r12_resume: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(resume_req) |-> !wse && !wsp);
endmodule

bind sfsr_status_ctrl sfsr_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wip(wip_q), .wel(wel_q), .srp(srp_q), .bp(bp_q),
  .hpm(hpm), .otp_lock(otp_lock_o), .fail(fail_o), .wse(wse_o), .wsp(wsp_o),
  .op_fail(op_fail), .resume_req(resume_req)
);

// File: tb/sfsr_status_ctrl_tb.sv
`timescale 1ns/1ps
module sfsr_status_ctrl_tb;
  localparam int WRC = 600;
  localparam int H   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1, otp_mode = 1'b0;
  logic susp_req = 1'b0, resume_req = 1'b0, op_erase = 1'b0;
  logic op_start = 1'b0, op_fail = 1'b0, soft_rst = 1'b0;
  logic miso, wip_o, fail_o, wse_o, wsp_o, otp_lock_o;

  int checks = 0, errors = 0;
  int run = 0, last_run = 0;
  logic m_srp = 1'b0, m_wel = 1'b0;
  logic [3:0] m_bp = '0;

  always #4 clk = ~clk;

  sfsr_status_ctrl #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .wp_n(wp_n), .otp_mode(otp_mode), .susp_req(susp_req),
    .resume_req(resume_req), .op_erase(op_erase), .op_start(op_start),
    .op_fail(op_fail), .soft_rst(soft_rst), .wip_o(wip_o), .fail_o(fail_o),
    .wse_o(wse_o), .wsp_o(wsp_o), .otp_lock_o(otp_lock_o)
  );

  always @(negedge clk) begin
    if (wip_o) run++;
    else if (run != 0) begin
      last_run = run;
      run = 0;
    end
  end

  function automatic logic [7:0] exp_stat(logic s, logic [3:0] b, logic we, logic wi);
    return {s, 1'b0, b, we, wi};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clkw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    logic [31:0] t;
    t = tx;
    rx = '0;
    cs_n = 1'b0;
    clkw(H);
    for (int i = 0; i < nbits; i++) begin
      mosi = t[31];
      t = t << 1;
      clkw(H);
      sclk = 1'b1;
      rx = {rx[30:0], miso};
      clkw(H);
      sclk = 1'b0;
    end
    clkw(H);
    cs_n = 1'b1;
    mosi = 1'b0;
    clkw(2 * H);
  endtask

  task automatic send(input logic [31:0] tx, input int nbits);
    logic [31:0] rx;
    spi_xfer(tx, nbits, rx);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [31:0] rx;
    spi_xfer({8'h05, 24'h0}, 16, rx);
    s = rx[7:0];
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * WRC && wip_o; i++) clkw(1);
    clkw(2);
  endtask

  // bench model of one frame (issued while idle)
  task automatic model_frame(logic [7:0] op, logic [7:0] d, int nbits);
    if (op == 8'h06 && nbits == 8) m_wel = 1'b1;
    if (op == 8'h01 && nbits == 16 && m_wel && !(m_srp && !wp_n)) begin
      m_srp = d[7];
      m_bp = d[5:2];
      m_wel = 1'b0;
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    clkw(1);
    sig = 1'b0;
    clkw(1);
  endtask

  initial begin
    logic [7:0] s;
    logic [31:0] rx;
    void'($urandom(32'd20240611));
    clkw(5);
    rst = 1'b0;
    clkw(5);

    // R1 reset state
    check("R1 miso", miso, 0);
    check("R1 flags", {wip_o, fail_o, wse_o, wsp_o, otp_lock_o}, 0);
    rd_status(s);
    check("R1 status", s, 8'h00);

    // R4 write without latch
    send({8'h01, 8'hFC, 16'h0}, 16);
    wait_idle();
    rd_status(s);
    check("R4 no latch", s, 8'h00);

    // R3 wrong length then exact
    send({8'h06, 8'hFF, 16'h0}, 9);
    rd_status(s);
    check("R3 9 bits", s, 8'h00);
    send({8'h06, 24'h0}, 8);
    rd_status(s);
    check("R3 set latch", s, 8'h02);

    // R5 short and long frames cancelled
    send({8'h01, 8'hFC, 16'h0}, 15);
    wait_idle();
    rd_status(s);
    check("R5 15 bits", s, 8'h02);
    send({8'h01, 8'hFC, 16'h0}, 17);
    wait_idle();
    rd_status(s);
    check("R5 17 bits", s, 8'h02);

    // R6 R8 accepted write, read while busy
    last_run = 0;
    send({8'h01, 8'hFF, 16'h0}, 16);
    rd_status(s);
    check("R6 R8 busy read", s, 8'hBF);
    // R13 write while busy ignored
    send({8'h01, 8'h00, 16'h0}, 16);
    wait_idle();
    check("R6 busy length", last_run, WRC);
    // R2 two-byte read, R7 latch cleared
    spi_xfer({8'h05, 24'h0}, 24, rx);
    check("R7 R13 byte1", rx[15:8], 8'hBC);
    check("R2 byte2", rx[7:0], 8'hBC);
    m_srp = 1'b1; m_bp = 4'hF; m_wel = 1'b0;

    // R9 hardware protection
    wp_n = 1'b0;
    send({8'h06, 24'h0}, 8);
    send({8'h01, 8'h00, 16'h0}, 16);
    wait_idle();
    rd_status(s);
    check("R9 locked", s, 8'hBE);
    wp_n = 1'b1;
    clkw(4);
    send({8'h01, 8'h00, 16'h0}, 16);
    wait_idle();
    rd_status(s);
    check("R9 unlocked", s, 8'h00);
    m_srp = 1'b0; m_bp = 4'h0;

    // R10 OTP mode
    otp_mode = 1'b1;
    last_run = 0;
    send({8'h06, 24'h0}, 8);
    send({8'h01, 8'h84, 16'h0}, 16);
    wait_idle();
    rd_status(s);
    check("R10 status kept", s, 8'h00);
    check("R10 lock", otp_lock_o, 1);
    check("R10 busy ran", last_run, WRC);
    otp_mode = 1'b0;

    // R11 fail flag
    pulse(op_fail);
    check("R11 set", fail_o, 1);
    op_fail = 1'b1; op_start = 1'b1; clkw(1); op_fail = 1'b0; op_start = 1'b0; clkw(1);
    check("R11 priority", fail_o, 1);
    pulse(op_start);
    check("R11 start clr", fail_o, 0);
    pulse(op_fail);
    pulse(soft_rst);
    check("R11 soft clr", fail_o, 0);

    // R12 suspend flags
    op_erase = 1'b1;
    pulse(susp_req);
    check("R12 erase susp", {wse_o, wsp_o}, 2'b10);
    pulse(resume_req);
    check("R12 resume", {wse_o, wsp_o}, 2'b00);
    op_erase = 1'b0;
    pulse(susp_req);
    check("R12 prog susp", {wse_o, wsp_o}, 2'b01);
    susp_req = 1'b1; resume_req = 1'b1; clkw(1); susp_req = 1'b0; resume_req = 1'b0; clkw(1);
    check("R12 resume wins", {wse_o, wsp_o}, 2'b00);

    // random mix, R3 R4 R5 R8 R9 R13
    for (int it = 0; it < 40; it++) begin
      int act, nb;
      logic [7:0] d, op;
      act = $urandom % 5;
      d = 8'($urandom);
      case (act)
        0: begin send({8'h06, 24'h0}, 8); model_frame(8'h06, 0, 8); end
        1: begin send({8'h01, d, 16'h0}, 16); model_frame(8'h01, d, 16); end
        2: begin
          nb = 9 + ($urandom % 15);
          if (nb == 16) nb = 17;
          send({8'h01, d, 16'h0}, nb);
          model_frame(8'h01, d, nb);
        end
        3: begin wp_n = 1'($urandom); clkw(4); end
        default: begin
          op = 8'($urandom);
          if (op == 8'h01 || op == 8'h05 || op == 8'h06) op = 8'h9F;
          send({op, d, 16'h0}, 16);
        end
      endcase
      wait_idle();
      rd_status(s);
      check("R8 R9 random", s, exp_stat(m_srp, m_bp, m_wel, 1'b0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R1..all actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule